// File: doc/BRIEF.md
# Word-Boundary Serializer

This block turns 12-bit parallel words into a serial stream in which each word takes 14 bit times. It also produces a clock level that travels with the data. The block is clocked by a bit-time tick, one tick per serial bit, which comes from a frequency multiplier outside this block. A rising edge on the strobe input captures the parallel word into a one-word holding register, and the word waits there until the next frame slot takes it. When a frame slot opens and no word is waiting, an all-zero word is sent.

Word framing is carried in the clock level. The clock toggles every bit time, except that one low phase is left out at the end of each frame, so the clock stays high for three bit times in a row. During that high window the serializer sends two extra bits taken from the last data bit: first its inverse, then its true value. This guarantees a data transition inside the window, which a receiver can use to find the word boundary. Data and clock are both registered, so they change on the same tick edge.

Top module: `wordmark_serializer`

## Requirements
- R1: Within a frame, slots 0 to 11 carry din[0] through din[11] in that order, least significant bit first.
- R2: Slot 12 carries the inverse of din[11] and slot 13 carries din[11], so the data level changes between slot 12 and slot 13.
- R3: The clock level is low in the even slots 0 to 10 and high in every odd slot and in slot 12. This gives exactly one three-bit-time high window (slots 11, 12 and 13) per 14-slot frame. A low level never lasts more than one bit time.
- R4: din is sampled at the third tick edge after strobe rises (a two-stage synchronizer followed by an edge detector). The word is sent in the first frame whose load edge comes strictly after the sampling edge. The load edge is the edge that moves the slot counter from 13 back to 0.
- R5: A frame whose load edge finds no pending word carries the value zero in slots 0 to 11, with the matching boundary bits: 1 in slot 12 and 0 in slot 13.
- R6: If a second word is captured before the pending word has been sent, the newer word replaces the older one, and only the newer word is sent.
- R7: While rst is high, both outputs are high, the slot counter is 0 and any pending word is discarded. The first tick edge after release enters slot 1 of an all-zero frame.
- R8: A strobe that stays high captures exactly one word. Changes on din while strobe stays high are not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-time tick clock, 14 ticks per word period |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Word capture strobe, asynchronous to clk_bit; acts on its rising edge |
| din | input | WORD_W | Parallel word; must be held stable for at least three ticks after strobe rises |
| ser_data | output | 1 | Serial data level, one bit per tick |
| ser_clk | output | 1 | Serial clock level with the embedded word boundary |

## Verification
The output seen after tick edge e belongs to slot e mod 14 of frame e div 14, counted from the first edge after reset. A strobe raised between edges E and E+1 is sampled at edge E+3. The bench therefore places each word in frame (E+3) div 14 + 1 and predicts every output bit from those two formulas alone. The bench compares both outputs once per tick on the falling clock edge, after all registers have settled. Strobes are placed at all 14 slot phases, including the phase where sampling lands exactly on the load edge, so the one-frame deferral is exercised.

// File: rtl/wordmark_serializer.sv
module wordmark_serializer #(
  parameter int WORD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              strobe,
  input  logic [WORD_W-1:0] din,
  output logic              ser_data,
  output logic              ser_clk
);
  localparam int FRAME_LEN = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [SYNC_STAGES-1:0] stb_sync;
  logic                   stb_prev;
  logic                   stb_rise;
  logic [WORD_W-1:0]      hold;
  logic                   pend;
  logic [CNT_W-1:0]       cnt;
  logic [WORD_W-1:0]      frame;
  logic                   slot;
  logic [CNT_W-1:0]       cnt_n;
  logic [WORD_W-1:0]      frame_n;
  logic                   data_n;
  logic                   clk_n;

  assign stb_rise = stb_sync[SYNC_STAGES-1] & ~stb_prev;
  assign slot     = (cnt == LAST);
  assign cnt_n    = slot ? '0 : cnt + CNT_W'(1);
  assign frame_n  = slot ? (pend ? hold : '0) : frame;
  assign clk_n    = cnt_n[0] | (int'(cnt_n) == WORD_W);

  always_comb begin
    if (int'(cnt_n) < WORD_W)
      data_n = frame_n[cnt_n];
    else if (int'(cnt_n) == WORD_W)
      data_n = ~frame_n[WORD_W-1];
    else
      data_n = frame_n[WORD_W-1];
  end

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      stb_sync <= '0;
      stb_prev <= 1'b0;
    end else begin
      stb_sync <= {stb_sync[SYNC_STAGES-2:0], strobe};
      stb_prev <= stb_sync[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      hold <= '0;
      pend <= 1'b0;
    end else if (stb_rise) begin
      hold <= din;
      pend <= 1'b1;
    end else if (slot) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      cnt      <= '0;
      frame    <= '0;
      ser_data <= 1'b1;
      ser_clk  <= 1'b1;
    end else begin
      cnt      <= cnt_n;
      frame    <= frame_n;
      ser_data <= data_n;
      ser_clk  <= clk_n;
    end
  end
endmodule

module wordmark_serializer_chk #(
  parameter int CNT_W = 4,
  parameter int LAST  = 13
) (
  input logic             clk_bit,
  input logic             rst,
  input logic             ser_data,
  input logic             ser_clk,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             stb_rise
);
  logic [3:0] hi_run;
  logic [1:0] since_rst;

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      hi_run    <= '0;
      since_rst <= '0;
    end else begin
      hi_run    <= ser_clk ? hi_run + 4'd1 : 4'd0;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  // R3
  clk_low_single_chk: assert property (@(posedge clk_bit) disable iff (rst)
    !ser_clk |=> ser_clk);

  // R3
  clk_high_run_chk: assert property (@(posedge clk_bit) disable iff (rst)
    hi_run <= 4'd3);

  // R2
  boundary_toggle_chk: assert property (@(posedge clk_bit) disable iff (rst)
    (since_rst == 2'd3 && ser_clk && $past(ser_clk) && $past(ser_clk, 2))
      |-> (ser_data != $past(ser_data)));

  // R4
  capture_pending_chk: assert property (@(posedge clk_bit) disable iff (rst)
    stb_rise |=> pend);

  // R5
  slot_consumes_chk: assert property (@(posedge clk_bit) disable iff (rst)
    (cnt == CNT_W'(LAST) && !stb_rise) |=> !pend);

  // R7
  reset_state_chk: assert property (@(posedge clk_bit)
    rst |=> (ser_data && ser_clk && !pend && cnt == '0));
endmodule

bind wordmark_serializer wordmark_serializer_chk #(
  .CNT_W(CNT_W),
  .LAST (FRAME_LEN - 1)
) u_chk (
  .clk_bit (clk_bit),
  .rst     (rst),
  .ser_data(ser_data),
  .ser_clk (ser_clk),
  .cnt     (cnt),
  .pend    (pend),
  .stb_rise(stb_rise)
);

// File: tb/wordmark_serializer_test.sv
`timescale 1ns/1ps
module wordmark_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [11:0] din = '0;
  logic        sd, sc;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit checking = 1'b0;
  string cur_req = "R1";
  logic [11:0] expw [0:511];

  always #2.5 clk = ~clk;

  wordmark_serializer uut (
    .clk_bit(clk), .rst(rst), .strobe(strobe), .din(din),
    .ser_data(sd), .ser_clk(sc)
  );

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  always @(negedge clk) begin
    if (checking && !rst && ecount > 0) begin
      int idx;
      int f;
      logic [11:0] w;
      logic exp_c;
      logic exp_d;
      idx = ecount % 14;
      f   = ecount / 14;
      w   = (f >= 1 && f < 512) ? expw[f] : 12'h000;
      exp_c = (idx % 2 == 1) || (idx == 12);
      if (idx < 12)       exp_d = w[idx];
      else if (idx == 12) exp_d = ~w[11];
      else                exp_d = w[11];
      checks++;
      if (sc !== exp_c) begin
        errors++;
        $display("FAIL R3 ser_clk tick %0d slot %0d got %b exp %b", ecount, idx, sc, exp_c);
      end
      checks++;
      if (sd !== exp_d) begin
        errors++;
        $display("FAIL %s ser_data tick %0d slot %0d got %b exp %b",
                 (idx >= 12) ? "R2" : cur_req, ecount, idx, sd, exp_d);
      end
    end
  end

  task automatic clear_exp();
    for (int i = 0; i < 512; i++) expw[i] = 12'h000;
  endtask

  task automatic align(input int p);
    @(negedge clk);
    while (ecount % 14 != p) @(negedge clk);
  endtask

  // called at a falling edge; word is sampled at edge ecount+3
  task automatic send(input logic [11:0] w);
    int c;
    c = ecount + 3;
    expw[c / 14 + 1] = w;
    strobe = 1'b1;
    din    = w;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_high(input string tag);
    checks++;
    if (sd !== 1'b1 || sc !== 1'b1) begin
      errors++;
      $display("FAIL %s reset outputs got %b%b exp 11", tag, sd, sc);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    summary();
  end

  initial begin
    clear_exp();
    repeat (3) @(negedge clk);
    // R7: outputs held high during reset
    check_high("R7");
    rst = 1'b0;
    checking = 1'b1;

    // R1: walking ones, one word per frame at varying phases
    cur_req = "R1";
    for (int i = 0; i < 12; i++) begin
      align(i);
      send(12'h001 << i);
    end
    align(0); send(12'hFFF);
    align(0); send(12'h555);
    align(0); send(12'hAAA);

    // R4: every slot phase, including sampling on the load edge
    cur_req = "R4";
    for (int p = 0; p < 14; p++) begin
      align(p);
      send(12'((p * 12'h259 + 12'h123) & 12'hFFF));
    end

    // R5: idle frames carry zero
    cur_req = "R5";
    repeat (42) @(negedge clk);

    // R6: two captures before one slot, newer wins
    cur_req = "R6";
    for (int k = 0; k < 3; k++) begin
      align(0);
      send(12'h3C0 + 12'(k));
      send(12'hC3F - 12'(k));
    end

    // R8: strobe held high across frames; later din changes ignored
    cur_req = "R8";
    align(2);
    begin
      int c;
      c = ecount + 3;
      expw[c / 14 + 1] = 12'h9A6;
      strobe = 1'b1;
      din = 12'h9A6;
      repeat (5) @(negedge clk);
      din = 12'h659;
      repeat (40) @(negedge clk);
      strobe = 1'b0;
      repeat (30) @(negedge clk);
    end

    // R7: reset mid-run discards a pending word
    cur_req = "R7";
    align(0);
    strobe = 1'b1;
    din = 12'h7E1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    checking = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_high("R7");
    clear_exp();
    rst = 1'b0;
    checking = 1'b1;
    repeat (45) @(negedge clk);

    checking = 1'b0;
    summary();
  end
endmodule